// File: doc/BRIEF.md
# Bit-Synchronous Receive Character Aligner and Filler Stripper

This block sits behind a serial line receiver that presents one bit at a time with a qualifying strobe. It first finds character boundaries by sliding a 16-bit window across the incoming bits until the window equals a configured two-byte alignment pattern. It then assembles 8-bit characters, least significant bit first, and removes link filler before handing payload bytes downstream one per cycle on a valid/data pair.

Two framing modes are supported. Normal mode drops every character equal to the configured fill character. Transparent mode uses an escape character. An escape followed by the fill character is dropped as a pair. Two escapes in a row yield one escape as data. An escape followed by anything else is passed through as two bytes, both marked as a control sequence. Each dropped fill character, and each dropped escape/fill pair, raises a strobe so that a downstream block-check unit can leave it out. The receiver returns to pattern search on a command, on an error input, or when a configured control character is recognised.

The controller states are IDLE, HUNT, RECV, DLE_HELD and SECOND, with these transitions:
- IDLE to HUNT on enable.
- HUNT to RECV on a pattern match.
- RECV to DLE_HELD on an escape in transparent mode.
- RECV to HUNT on a control character in normal mode.
- DLE_HELD to RECV on fill or escape.
- DLE_HELD to SECOND on any other character.
- SECOND to RECV, or to HUNT if the held character is the control character.
- Any state except IDLE to HUNT on a command or an error.
- Any state to IDLE when enable is low.

Top module: `bisync_rx_sync`

## Requirements
- R1: While reset or while `enable` is low, `in_sync`, `out_valid`, `bcs_skip` and `ctl_seq` are 0. After `enable` rises the block searches for the pattern with `in_sync` = 0.
- R2: During the search, each strobed bit enters a 16-bit window, first bit at the lowest position. A match occurs when the window equals {`syn_hi`,`syn_lo`}, which means `syn_lo` was sent first, LSB first. A match needs at least 16 bits since the search began. `in_sync` is 1 from the cycle after the edge that samples the matching bit.
- R3: Characters are formed from the strobed bits that follow the match, 8 at a time, LSB first. A delivered character appears with `out_valid` = 1 for one cycle, in the cycle after the edge that samples its eighth bit.
- R4: In normal mode (`transparent` = 0), a character equal to `fill_char` is not delivered. It pulses `bcs_skip` instead. All other characters are delivered.
- R5: In transparent mode, an escape (`esc_char`) followed by `fill_char` delivers nothing and pulses `bcs_skip` on the second character. A `fill_char` not preceded by an escape is delivered as data.
- R6: In transparent mode, two escapes in a row deliver a single escape byte with `ctl_seq` = 0.
- R7: In transparent mode, an escape followed by any other character X delivers the escape and then X on the next cycle, both with `ctl_seq` = 1.
- R8: With `ctl_en` = 1, `ctl_char` is delivered and the block then returns to search (`in_sync` = 0 on the next cycle). In normal mode this applies to any occurrence of `ctl_char`. In transparent mode it applies only to the X of an escape-X pair. A bare `ctl_char` in transparent mode is plain data.
- R9: `hunt_cmd` or `err_in` returns the block to search on the next cycle. A character completing in the same cycle is not delivered, and a pending escape is discarded.
- R10: Lowering `enable` puts the block in IDLE on the next cycle. No characters are delivered while it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver enable |
| bit_valid | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | Serial data bit |
| transparent | input | 1 | 1 selects transparent mode |
| syn_lo | input | 8 | First byte of the alignment pattern |
| syn_hi | input | 8 | Second byte of the alignment pattern |
| fill_char | input | 8 | Fill character to strip |
| esc_char | input | 8 | Escape character (transparent mode) |
| ctl_char | input | 8 | Control character that ends reception |
| ctl_en | input | 1 | Enables control character recognition |
| hunt_cmd | input | 1 | Command: return to pattern search |
| err_in | input | 1 | Error condition: return to pattern search |
| out_valid | output | 1 | Delivered byte strobe |
| out_data | output | 8 | Delivered byte |
| ctl_seq | output | 1 | Byte belongs to an escape-X control sequence |
| bcs_skip | output | 1 | Stripped fill or escape/fill pair, exclude from block check |
| in_sync | output | 1 | Character alignment held |

## Verification
A character can finish assembly in the same cycle that `hunt_cmd` or `err_in` is raised. In that case the return to search must win, and the finished byte must not appear. The bench provokes this by lining up the command with the cycle that follows the eighth bit of a character. It then confirms that nothing was captured and that `in_sync` has dropped. A second collision, an error arriving while an escape is held, is judged the same way: the escape must never come out.

// File: rtl/bisync_rx_pkg.sv
package bisync_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_HUNT,
        RX_RECV,
        RX_DLE_HELD,
        RX_SECOND
    } rx_state_e;
endpackage

// File: rtl/bisync_sync_hunter.sv
module bisync_sync_hunter #(
    parameter int CHAR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  restart,
    input  logic                  bit_valid,
    input  logic                  bit_in,
    input  logic [2*CHAR_W-1:0]   pattern,
    output logic                  match
);
    localparam int PAT_W = 2 * CHAR_W;
    localparam int CNT_W = $clog2(PAT_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAT_W - 1);

    logic [PAT_W-1:0] window_q;
    logic [PAT_W-1:0] window_nxt;
    logic [CNT_W-1:0] seen_q;

    assign window_nxt = {bit_in, window_q[PAT_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            window_q <= '0;
            seen_q   <= '0;
        end else begin
            if (bit_valid) window_q <= window_nxt;
            if (!run || restart) begin
                seen_q <= '0;
            end else if (bit_valid && seen_q != CNT_FULL) begin
                seen_q <= seen_q + 1'b1;
            end
        end
    end

    assign match = run && !restart && bit_valid &&
                   (seen_q == CNT_FULL) && (window_nxt == pattern);
endmodule

// File: rtl/bisync_char_asm.sv
module bisync_char_asm #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data
);
    localparam int IDX_W = $clog2(CHAR_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CHAR_W - 1);

    logic [IDX_W-1:0]  idx_q;
    logic [CHAR_W-1:0] shift_q;
    logic              done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            shift_q <= '0;
            done_q  <= 1'b0;
        end else if (!run) begin
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= bit_valid && (idx_q == IDX_LAST);
            if (bit_valid) begin
                shift_q <= {bit_in, shift_q[CHAR_W-1:1]};
                idx_q   <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
            end
        end
    end

    assign char_valid = done_q;
    assign char_data  = shift_q;
endmodule

// File: rtl/bisync_rx_sync.sv
module bisync_rx_sync
    import bisync_rx_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              transparent,
    input  logic [CHAR_W-1:0] syn_lo,
    input  logic [CHAR_W-1:0] syn_hi,
    input  logic [CHAR_W-1:0] fill_char,
    input  logic [CHAR_W-1:0] esc_char,
    input  logic [CHAR_W-1:0] ctl_char,
    input  logic              ctl_en,
    input  logic              hunt_cmd,
    input  logic              err_in,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    output logic              ctl_seq,
    output logic              bcs_skip,
    output logic              in_sync
);
    rx_state_e         state_q, state_nxt;
    logic [CHAR_W-1:0] held_q;
    logic              restart;
    logic              hunting;
    logic              match;
    logic              ch_valid;
    logic [CHAR_W-1:0] ch;

    assign restart = hunt_cmd || err_in;
    assign hunting = (state_q == RX_HUNT);
    assign in_sync = (state_q == RX_RECV) || (state_q == RX_DLE_HELD) ||
                     (state_q == RX_SECOND);

    bisync_sync_hunter #(.CHAR_W(CHAR_W)) u_hunter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (hunting),
        .restart   (restart),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .pattern   ({syn_hi, syn_lo}),
        .match     (match)
    );

    bisync_char_asm #(.CHAR_W(CHAR_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (in_sync),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .char_valid (ch_valid),
        .char_data  (ch)
    );

    // state register and held character
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_nxt;
            if (state_q == RX_DLE_HELD && ch_valid) held_q <= ch;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        if (!enable) begin
            state_nxt = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE: state_nxt = RX_HUNT;
                RX_HUNT: begin
                    if (!restart && match) state_nxt = RX_RECV;
                end
                RX_RECV: begin
                    if (restart) begin
                        state_nxt = RX_HUNT;
                    end else if (ch_valid) begin
                        if (transparent && ch == esc_char)
                            state_nxt = RX_DLE_HELD;
                        else if (!transparent && ctl_en && ch == ctl_char)
                            state_nxt = RX_HUNT;
                    end
                end
                RX_DLE_HELD: begin
                    if (restart) begin
                        state_nxt = RX_HUNT;
                    end else if (ch_valid) begin
                        if (ch == fill_char || ch == esc_char)
                            state_nxt = RX_RECV;
                        else
                            state_nxt = RX_SECOND;
                    end
                end
                RX_SECOND: begin
                    if (restart || (ctl_en && held_q == ctl_char))
                        state_nxt = RX_HUNT;
                    else
                        state_nxt = RX_RECV;
                end
                default: state_nxt = RX_IDLE;
            endcase
        end
    end

    // output logic
    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        ctl_seq   = 1'b0;
        bcs_skip  = 1'b0;
        if (enable && !restart) begin
            unique case (state_q)
                RX_RECV: begin
                    if (ch_valid) begin
                        if (transparent) begin
                            if (ch != esc_char) begin
                                out_valid = 1'b1;
                                out_data  = ch;
                            end
                        end else if (ch == fill_char) begin
                            bcs_skip = 1'b1;
                        end else begin
                            out_valid = 1'b1;
                            out_data  = ch;
                        end
                    end
                end
                RX_DLE_HELD: begin
                    if (ch_valid) begin
                        if (ch == fill_char) begin
                            bcs_skip = 1'b1;
                        end else begin
                            out_valid = 1'b1;
                            out_data  = esc_char;
                            ctl_seq   = (ch != esc_char);
                        end
                    end
                end
                RX_SECOND: begin
                    out_valid = 1'b1;
                    out_data  = held_q;
                    ctl_seq   = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bisync_rx_chk.sv
module bisync_rx_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              hunt_cmd,
    input logic              err_in,
    input logic              transparent,
    input logic [CHAR_W-1:0] fill_char,
    input logic [CHAR_W-1:0] esc_char,
    input logic              out_valid,
    input logic [CHAR_W-1:0] out_data,
    input logic              ctl_seq,
    input logic              bcs_skip,
    input logic              in_sync
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!in_sync && !out_valid)); // R10

    AST_HUNT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (hunt_cmd || err_in)) |=> !in_sync); // R9

    AST_SKIP_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !(bcs_skip && out_valid)); // R4

    AST_VALID_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_sync); // R3

    AST_CTL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_seq |-> out_valid); // R7

    AST_CTL_SECOND_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ctl_seq && out_data == esc_char) |=>
        ((out_valid && ctl_seq) || !enable || hunt_cmd || err_in)); // R7

    AST_FILL_STRIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !transparent && $stable(transparent) && fill_char != esc_char)
        |-> out_data != fill_char); // R4
endmodule

bind bisync_rx_sync bisync_rx_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .hunt_cmd    (hunt_cmd),
    .err_in      (err_in),
    .transparent (transparent),
    .fill_char   (fill_char),
    .esc_char    (esc_char),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .ctl_seq     (ctl_seq),
    .bcs_skip    (bcs_skip),
    .in_sync     (in_sync)
);

// File: tb/bisync_rx_sync_test.sv
module bisync_rx_sync_test;
    localparam logic [7:0] SYN_LO = 8'hA5;
    localparam logic [7:0] SYN_HI = 8'h3C;
    localparam logic [7:0] FILL   = 8'h3C;
    localparam logic [7:0] ESC    = 8'h10;
    localparam logic [7:0] CTL    = 8'h03;

    typedef struct packed {
        logic       trans;
        logic [7:0] a;
        logic [7:0] b;
        logic [1:0] nout;
        logic [7:0] o0;
        logic [7:0] o1;
        logic [1:0] skips;
        logic [1:0] ctls;
        logic       sync_end;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h41, 8'h42, 2'd2, 8'h41, 8'h42, 2'd0, 2'd0, 1'b1}, // R3
        '{1'b0, 8'h3C, 8'h55, 2'd1, 8'h55, 8'h00, 2'd1, 2'd0, 1'b1}, // R4
        '{1'b0, 8'h10, 8'h3C, 2'd1, 8'h10, 8'h00, 2'd1, 2'd0, 1'b1}, // R4
        '{1'b1, 8'h10, 8'h3C, 2'd0, 8'h00, 8'h00, 2'd1, 2'd0, 1'b1}, // R5
        '{1'b1, 8'h3C, 8'h66, 2'd2, 8'h3C, 8'h66, 2'd0, 2'd0, 1'b1}, // R5
        '{1'b1, 8'h10, 8'h10, 2'd1, 8'h10, 8'h00, 2'd0, 2'd0, 1'b1}, // R6
        '{1'b1, 8'h10, 8'h77, 2'd2, 8'h10, 8'h77, 2'd0, 2'd2, 1'b1}, // R7
        '{1'b0, 8'h03, 8'h88, 2'd1, 8'h03, 8'h00, 2'd0, 2'd0, 1'b0}, // R8
        '{1'b1, 8'h03, 8'h99, 2'd2, 8'h03, 8'h99, 2'd0, 2'd0, 1'b1}, // R8
        '{1'b1, 8'h10, 8'h03, 2'd2, 8'h10, 8'h03, 2'd0, 2'd2, 1'b0}  // R8
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       transparent = 1'b0;
    logic       ctl_en = 1'b1;
    logic       hunt_cmd = 1'b0;
    logic       err_in = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       ctl_seq;
    logic       bcs_skip;
    logic       in_sync;

    int checks = 0;
    int failures = 0;
    int n_cap = 0;
    int n_skip = 0;
    int n_ctl = 0;
    logic [7:0] cap [4];

    always #2 clk = ~clk;

    bisync_rx_sync uut (
        .clk (clk), .rst_n (rst_n), .enable (enable),
        .bit_valid (bit_valid), .bit_in (bit_in), .transparent (transparent),
        .syn_lo (SYN_LO), .syn_hi (SYN_HI), .fill_char (FILL),
        .esc_char (ESC), .ctl_char (CTL), .ctl_en (ctl_en),
        .hunt_cmd (hunt_cmd), .err_in (err_in),
        .out_valid (out_valid), .out_data (out_data), .ctl_seq (ctl_seq),
        .bcs_skip (bcs_skip), .in_sync (in_sync)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            if (n_cap < 4) cap[n_cap] = out_data;
            n_cap++;
            if (ctl_seq) n_ctl++;
        end
        if (bcs_skip) n_skip++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(posedge clk); #1;
        bit_valid = 1'b1;
        bit_in    = b;
    endtask

    task automatic step();
        @(posedge clk); #1;
        bit_valid = 1'b0;
    endtask

    task automatic send_char(input logic [7:0] c);
        for (int i = 0; i < 8; i++) send_bit(c[i]);
        step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_cap();
        n_cap = 0; n_skip = 0; n_ctl = 0;
    endtask

    task automatic pulse_hunt();
        @(posedge clk); #1; hunt_cmd = 1'b1;
        @(posedge clk); #1; hunt_cmd = 1'b0;
    endtask

    task automatic acquire();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        for (int i = 0; i < 8; i++) send_bit(SYN_LO[i]);
        for (int i = 0; i < 8; i++) send_bit(SYN_HI[i]);
        step();
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 reset and disabled state
        idle(3);
        @(negedge clk);
        chk("R1 in_sync", in_sync, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 bcs_skip", bcs_skip, 0);
        chk("R1 ctl_seq", ctl_seq, 0);
        @(posedge clk); #1; rst_n = 1'b1; enable = 1'b1;
        idle(2);
        @(negedge clk);
        chk("R1 hunting after enable", in_sync, 0);

        // R2 match needs the sixteenth bit
        for (int i = 0; i < 8; i++) send_bit(SYN_LO[i]);
        for (int i = 0; i < 7; i++) send_bit(SYN_HI[i]);
        step();
        @(negedge clk);
        chk("R2 no sync after 15 bits", in_sync, 0);
        send_bit(SYN_HI[7]);
        step();
        @(negedge clk);
        chk("R2 sync after 16th bit", in_sync, 1);

        // R3 exact output cycle with back-to-back bits
        clear_cap();
        for (int i = 0; i < 8; i++) send_bit(8'h5A >> i);
        step();
        @(negedge clk);
        chk("R3 valid after 8th bit", out_valid, 1);
        chk("R3 data", out_data, 8'h5A);
        idle(2);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            transparent = VECS[v].trans;
            pulse_hunt();
            acquire();
            @(negedge clk);
            chk($sformatf("R2 vec%0d sync", v), in_sync, 1);
            clear_cap();
            send_char(VECS[v].a);
            send_char(VECS[v].b);
            idle(3);
            @(negedge clk);
            chk($sformatf("vec%0d count (R3-R8)", v), n_cap, VECS[v].nout);
            if (VECS[v].nout > 0) chk($sformatf("vec%0d byte0 (R3-R8)", v), cap[0], VECS[v].o0);
            if (VECS[v].nout > 1) chk($sformatf("vec%0d byte1 (R3-R8)", v), cap[1], VECS[v].o1);
            chk($sformatf("vec%0d skips R4 R5", v), n_skip, VECS[v].skips);
            chk($sformatf("vec%0d ctl_seq R7", v), n_ctl, VECS[v].ctls);
            chk($sformatf("vec%0d end sync R8", v), in_sync, VECS[v].sync_end);
        end

        // R9 hunt command collides with a completed character
        transparent = 1'b0;
        pulse_hunt();
        acquire();
        clear_cap();
        for (int i = 0; i < 8; i++) send_bit(8'h47 >> i);
        @(posedge clk); #1; bit_valid = 1'b0; hunt_cmd = 1'b1;
        @(posedge clk); #1; hunt_cmd = 1'b0;
        idle(2);
        @(negedge clk);
        chk("R9 collided char dropped", n_cap, 0);
        chk("R9 back to hunt", in_sync, 0);

        // R9 error while an escape is held
        transparent = 1'b1;
        pulse_hunt();
        acquire();
        clear_cap();
        send_char(ESC);
        @(posedge clk); #1; err_in = 1'b1;
        @(posedge clk); #1; err_in = 1'b0;
        send_char(8'h77);
        idle(2);
        @(negedge clk);
        chk("R9 held escape discarded", n_cap, 0);
        chk("R9 error hunt", in_sync, 0);

        // R10 disable while aligned
        transparent = 1'b0;
        pulse_hunt();
        acquire();
        @(posedge clk); #1; enable = 1'b0;
        clear_cap();
        send_char(8'h61);
        idle(2);
        @(negedge clk);
        chk("R10 idle no sync", in_sync, 0);
        chk("R10 nothing delivered", n_cap, 0);
        @(posedge clk); #1; enable = 1'b1;
        idle(2);
        @(negedge clk);
        chk("R10 re-enable hunts", in_sync, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule